// File: doc/BRIEF.md
# Waveform Sample Low-Pass Path

This block conditions signed 16-bit voltage-channel samples before they reach a waveform capture register. Every accepted sample updates a single-pole IIR low-pass filter, `y <- y + (x - y) / 2^k`. The filter state carries extra fractional bits. With an input rate of about 27.9 kHz and k = 5, the corner lands near 140 Hz. At the 50/60 Hz line frequency this gives a small, predictable attenuation of roughly 0.5 to 0.7 dB.

The filtered value is rounded back to 16 bits and sign-extended to a 24-bit word. That word is registered out with a one-cycle valid strobe, but only when the 2-bit mode field selects voltage waveform capture (binary 11) and the waveform-sample enable is set. The filter keeps running whatever the mode is, so it is already settled when capture is switched on.

Top module: `wave_lpf_path`

## Requirements
- R1: A synchronous active-high reset clears the filter state to zero and drives `wave_valid` low and `wave_data` to zero.
- R2: `wave_valid` rises exactly one clock after a cycle in which `smp_valid` is high, `mode_sel` equals binary 11 and `wave_en` is 1.
- R3: In every other case `wave_valid` is low in the next cycle and `wave_data` keeps its previous value.
- R4: Each valid sample updates the state as acc += ((x << 8) - acc) >>> 5, with 8 fractional bits. The output is acc rounded to an integer, so from reset a single sample of 0x4000 yields 0x000200.
- R5: The filter state updates on every valid sample, whatever `mode_sel` and `wave_en` are. A sample issued after a long disabled run therefore reflects that run.
- R6: Output bits 23..16 replicate bit 15 of the rounded 16-bit result. From reset, a single sample of 0x8000 yields 0xFFFC00.
- R7: A constant input settles to exactly the input value within 600 samples. This holds for both full-scale codes: 0x2852 gives 0x002852, and 0xD7AE gives 0xFFD7AE.
- R8: A 60 Hz sine sampled at 465 samples per period comes out with a peak between 0.90 and 0.94 of the input peak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Input sample strobe |
| smp_data | input | 16 | Signed two's-complement ADC sample |
| mode_sel | input | 2 | Waveform source select; 2'b11 selects this channel |
| wave_en | input | 1 | Waveform sampling enable |
| wave_valid | output | 1 | Output strobe, one clock after an accepted sample |
| wave_data | output | 24 | Filtered sample, sign-extended, held between strobes |

## Verification
The gating logic is tried with a single sample under all eight combinations of mode and enable. This separates a decode that checks only part of the mode field, or ignores the enable. Single steps from reset with 0x4000 and 0x8000 pin down the shift amount, the fractional width, the rounding and the sign extension. Long constant runs at both full-scale codes show exact settling and catch truncation that stalls one LSB low. A sampled 60 Hz sine measures the gain, which separates the intended corner from a neighbouring shift value. A disabled run followed by one enabled sample shows that the filter keeps updating while capture is off.

// File: rtl/wlp_pkg.sv
package wlp_pkg;
  localparam int unsigned MODE_W = 2;
  typedef logic [MODE_W-1:0] wave_mode_t;
  localparam wave_mode_t MODE_VOLT_WAVE = 2'b11;
endpackage

// File: rtl/wlp_iir.sv
module wlp_iir #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned FRAC_W    = 8,
  parameter int unsigned SHIFT     = 5,
  parameter bit          ROUND_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_data,
  output logic signed [DATA_W-1:0] filt_next
);
  localparam int unsigned ACC_W = DATA_W + FRAC_W;
  localparam int unsigned DIF_W = ACC_W + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_d;
  logic signed [DIF_W-1:0] target;
  logic signed [DIF_W-1:0] diff;
  logic signed [DIF_W-1:0] step;
  logic signed [DIF_W-1:0] sum;

  always_comb begin
    target = {smp_data[DATA_W-1], smp_data, {FRAC_W{1'b0}}};
    diff   = target - {acc_q[ACC_W-1], acc_q};
    step   = diff >>> SHIFT;
    sum    = {acc_q[ACC_W-1], acc_q} + step;
    acc_d  = ACC_W'(sum);
  end

  // Output quantisation variant chosen by parameter
  generate
    if (ROUND_OUT) begin : g_round
      logic signed [DIF_W-1:0] rnd;
      always_comb begin
        rnd       = {acc_d[ACC_W-1], acc_d} + DIF_W'(1 << (FRAC_W - 1));
        filt_next = DATA_W'(rnd >>> FRAC_W);
      end
    end else begin : g_trunc
      always_comb filt_next = DATA_W'(acc_d >>> FRAC_W);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)            acc_q <= '0;
    else if (smp_valid) acc_q <= acc_d;
  end
endmodule

// File: rtl/wlp_out_stage.sv
module wlp_out_stage #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic signed [IN_W-1:0] din,
  output logic                   wave_valid,
  output logic [OUT_W-1:0]       wave_data
);
  localparam int unsigned EXT_W = OUT_W - IN_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_valid <= 1'b0;
      wave_data  <= '0;
    end else begin
      wave_valid <= load;
      if (load) wave_data <= {{EXT_W{din[IN_W-1]}}, din};
    end
  end
endmodule

// File: rtl/wave_lpf_path.sv
module wave_lpf_path
  import wlp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OUT_W  = 24,
  parameter int unsigned FRAC_W = 8,
  parameter int unsigned SHIFT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic              wave_en,
  output logic              wave_valid,
  output logic [OUT_W-1:0]  wave_data
);
  logic                     chan_sel;
  logic                     load;
  logic signed [DATA_W-1:0] filt_next;

  assign chan_sel = (mode_sel == MODE_VOLT_WAVE) && wave_en;
  assign load     = smp_valid && chan_sel;

  wlp_iir #(
    .DATA_W(DATA_W), .FRAC_W(FRAC_W), .SHIFT(SHIFT), .ROUND_OUT(1'b1)
  ) u_iir (
    .clk(clk), .rst(rst), .smp_valid(smp_valid),
    .smp_data(signed'(smp_data)), .filt_next(filt_next)
  );

  wlp_out_stage #(.IN_W(DATA_W), .OUT_W(OUT_W)) u_out (
    .clk(clk), .rst(rst), .load(load), .din(filt_next),
    .wave_valid(wave_valid), .wave_data(wave_data)
  );
endmodule

// File: rtl/wlp_chk.sv
module wlp_chk
  import wlp_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OUT_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_valid,
  input logic [MODE_W-1:0] mode_sel,
  input logic              wave_en,
  input logic              wave_valid,
  input logic [OUT_W-1:0]  wave_data
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!wave_valid && wave_data == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && mode_sel == MODE_VOLT_WAVE && wave_en) |=> wave_valid);

  // R3
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !(smp_valid && mode_sel == MODE_VOLT_WAVE && wave_en) |=> !wave_valid);

  // R3
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    !wave_valid |-> $stable(wave_data));

  // R6
  sext_chk: assert property (@(posedge clk) disable iff (rst)
    wave_valid |-> (wave_data[OUT_W-1:DATA_W-1] == '0 ||
                    wave_data[OUT_W-1:DATA_W-1] == '1));
endmodule

bind wave_lpf_path wlp_chk #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .mode_sel(mode_sel),
  .wave_en(wave_en), .wave_valid(wave_valid), .wave_data(wave_data)
);

// File: tb/tb_wave_lpf_path.sv
`timescale 1ns/1ps
module tb_wave_lpf_path;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [15:0] smp_data = '0;
  logic [1:0]  mode_sel = 2'b00;
  logic        wave_en = 1'b0;
  logic        wave_valid;
  logic [23:0] wave_data;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wave_lpf_path dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .mode_sel(mode_sel), .wave_en(wave_en),
    .wave_valid(wave_valid), .wave_data(wave_data)
  );

  // {mode, enable, expected valid}
  localparam logic [3:0] GATE_VEC [8] = '{
    4'b00_0_0, 4'b00_1_0, 4'b01_0_0, 4'b01_1_0,
    4'b10_0_0, 4'b10_1_0, 4'b11_0_0, 4'b11_1_1
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with outputs settled
  task automatic push(input logic [15:0] x);
    smp_data  = x;
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int peak;
    int sv;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk(wave_valid == 1'b0, "R1 valid", int'(wave_valid), 0);
    chk(wave_data == 24'h0, "R1 data", int'(wave_data), 0);

    // R2 / R3 gating table
    for (int i = 0; i < 8; i++) begin
      mode_sel = GATE_VEC[i][3:2];
      wave_en  = GATE_VEC[i][1];
      push(16'h0000);
      chk(wave_valid == GATE_VEC[i][0], GATE_VEC[i][0] ? "R2 gate" : "R3 gate",
          int'(wave_valid), int'(GATE_VEC[i][0]));
      @(negedge clk);
      chk(wave_valid == 1'b0, "R2 single strobe", int'(wave_valid), 0);
    end

    // R4 first step from reset
    do_reset();
    mode_sel = 2'b11; wave_en = 1'b1;
    push(16'h4000);
    chk(wave_data == 24'h000200, "R4 step", int'(wave_data), 'h200);

    // R3 hold while disabled
    wave_en = 1'b0;
    push(16'h4000);
    chk(wave_valid == 1'b0, "R3 valid", int'(wave_valid), 0);
    chk(wave_data == 24'h000200, "R3 hold", int'(wave_data), 'h200);

    // R1 reset clears filter state: same first step again
    do_reset();
    chk(wave_data == 24'h0, "R1 data mid-run", int'(wave_data), 0);
    wave_en = 1'b1;
    push(16'h4000);
    chk(wave_data == 24'h000200, "R1 state cleared", int'(wave_data), 'h200);

    // R6 negative sign extension
    do_reset();
    push(16'h8000);
    chk(wave_data == 24'hFFFC00, "R6 sext", int'(wave_data), 'hFFFC00);

    // R5 filter runs while disabled
    do_reset();
    mode_sel = 2'b01; wave_en = 1'b1;
    for (int i = 0; i < 700; i++) push(16'd5000);
    chk(wave_valid == 1'b0, "R5 quiet", int'(wave_valid), 0);
    mode_sel = 2'b11;
    push(16'd5000);
    chk(wave_data == 24'd5000, "R5 state", int'(wave_data), 5000);

    // R7 settling at both full-scale codes
    do_reset();
    for (int i = 0; i < 600; i++) push(16'h2852);
    chk(wave_data == 24'h002852, "R7 pos", int'(wave_data), 'h2852);
    for (int i = 0; i < 600; i++) push(16'hD7AE);
    chk(wave_data == 24'hFFD7AE, "R7 neg", int'(wave_data), 'hFFD7AE);

    // R8 60 Hz sine, 465 samples per period, amplitude 10000
    do_reset();
    peak = 0;
    for (int n = 0; n < 8 * 465; n++) begin
      sv = $rtoi(10000.0 * $sin(6.283185307179586 * n / 465.0));
      push(16'(sv));
      if (n >= 6 * 465 && $signed(wave_data) > peak) peak = $signed(wave_data);
    end
    chk(peak >= 9000 && peak <= 9400, "R8 gain", peak, 9200);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule